// File: doc/BRIEF.md
# Converter Auto-Trigger Source Selector

This block sits beside an analog-to-digital converter core and decides when the core starts a conversion on its own. It picks one level signal from a set of interrupt-flag sources. One of them is the converter's own completion flag. The others are flags from peripherals such as the comparator, an external interrupt, timer compare and overflow events, and the watchdog. The block issues a start pulse, one clock cycle wide, when the chosen level rises.

Edge detection works on the multiplexed level, not on each source. Changing the select from a source that is low to one that is high therefore counts as a rising edge and fires a start. Selecting the converter's own completion flag (free-running operation) is the exception: the switch alone never fires, even if that flag is already high. The block also tracks whether a conversion is in flight. It drops trigger edges that arrive during a conversion, and it delays channel/gain select writes made during a conversion until that conversion completes.

Top module: `adc_trig_sel`

## Requirements
- R1: After reset, `start_o` is 0 and `chan_sel_o` is 0.
- R2: Select code 0 picks `done_flag_i`. Code k (1 to 7) picks `periph_flag_i[k-1]`, in this order: comparator, external interrupt 0, timer 0 compare A, timer 0 overflow, timer 0 compare B, timer 1 overflow, watchdog. When the chosen level goes from 0 to 1 while the block is idle and enabled, `start_o` is 1 in the cycle after the edge.
- R3: With the select held at a source that is low, changing the select to a nonzero code whose source is high gives a start pulse one cycle later.
- R4: Changing the select to code 0 from any other code never gives a start pulse, even when `done_flag_i` is already 1.
- R5: While `auto_en_i` is 0, no start pulse is produced. The muxed level is still recorded every cycle. Raising `auto_en_i` while the chosen source is already high therefore gives no pulse.
- R6: While `conv_en_i` is 0, no start pulse is produced, and any conversion in flight is treated as abandoned.
- R7: A conversion is in flight from its start pulse until `done_flag_i` rises. A trigger edge during that time is dropped and not queued. An edge in the same cycle that `done_flag_i` rises is accepted.
- R8: A write (`chan_wr_i` = 1) while idle appears on `chan_sel_o` one cycle later. A write while a conversion is in flight is held and appears one cycle after `done_flag_i` rises. A later held write replaces an earlier one.
- R9: A start pulse lasts exactly one cycle, even if the chosen source stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| periph_flag_i | input | NSRC-1 | Peripheral flag levels for select codes 1 and up |
| done_flag_i | input | 1 | Converter completion flag level (code 0 source) |
| src_sel_i | input | SELW | Trigger source select code |
| auto_en_i | input | 1 | Auto-trigger enable |
| conv_en_i | input | 1 | Converter enable |
| chan_wr_i | input | 1 | Channel/gain select write strobe |
| chan_wdata_i | input | CHW | Channel/gain select write value |
| start_o | output | 1 | Single-cycle conversion start pulse |
| chan_sel_o | output | CHW | Channel/gain select applied to the converter |

## Verification
The bench targets switching the select into code 0 while the completion flag is high. A design that edge-detects without the free-running exception would fire a start there. It also raises the auto-trigger enable while the source is already high. A design that stops sampling the level while disabled would then see a false edge from stale history. Trigger edges are raised during a conversion and again in the exact completion cycle. Queuing the first would give a late pulse, and gating the second would stall free-running operation. Channel writes are placed during a conversion, and several are stacked before completion. A design that applies them at once, or keeps the first instead of the last, would show the wrong value on `chan_sel_o`.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

   // True when n is a power of two no smaller than two.
   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   // Variant choice for the source multiplexer.
   typedef enum logic [0:0] {
      MUX_INDEXED = 1'b0,
      MUX_ANDOR   = 1'b1
   } mux_style_e;

endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux
   import adc_trig_pkg::*;
#(
   parameter int         NSRC  = 8,
   parameter mux_style_e STYLE = MUX_ANDOR,
   localparam int        SELW  = $clog2(NSRC)
) (
   input  logic [NSRC-2:0] periph_i,
   input  logic            done_i,
   input  logic [SELW-1:0] sel_i,
   output logic            lvl_o
);

   logic [NSRC-1:0] src_vec;
   assign src_vec = {periph_i, done_i};

   generate
      if (STYLE == MUX_ANDOR) begin : g_andor
         logic [NSRC-1:0] hit;
         for (genvar g = 0; g < NSRC; g++) begin : g_hit
            assign hit[g] = (sel_i == SELW'(g)) & src_vec[g];
         end
         assign lvl_o = |hit;
      end else begin : g_index
         assign lvl_o = src_vec[sel_i];
      end
   endgenerate

endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
   parameter int            SELW      = 3,
   parameter logic [SELW-1:0] FREE_CODE = '0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            lvl_i,
   input  logic [SELW-1:0] sel_i,
   output logic            edge_o
);

   logic            lvl_q;
   logic [SELW-1:0] sel_q;
   logic            to_free;

   // History is kept every cycle, regardless of any enable.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lvl_q <= 1'b0;
         sel_q <= FREE_CODE;
      end else begin
         lvl_q <= lvl_i;
         sel_q <= sel_i;
      end
   end

   assign to_free = (sel_i == FREE_CODE) && (sel_q != FREE_CODE);
   assign edge_o  = lvl_i & ~lvl_q & ~to_free;

   // R3/R2: a recorded low followed by a high must be seen as an edge unless entering free-run
   a_r3_edge_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lvl_i ##1 (lvl_i && sel_i != FREE_CODE)) |-> edge_o);

endmodule

// File: rtl/conv_tracker.sv
module conv_tracker (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic edge_i,
   input  logic auto_en_i,
   input  logic conv_en_i,
   input  logic done_flag_i,
   output logic start_o,
   output logic busy_o,
   output logic done_evt_o
);

   logic done_q;
   logic busy_q;
   logic start_q;
   logic accept;

   assign done_evt_o = done_flag_i & ~done_q;
   assign accept     = edge_i & auto_en_i & conv_en_i & (~busy_q | done_evt_o);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_q  <= 1'b0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         done_q  <= done_flag_i;
         start_q <= accept;
         if (!conv_en_i)      busy_q <= 1'b0;
         else if (accept)     busy_q <= 1'b1;
         else if (done_evt_o) busy_q <= 1'b0;
      end
   end

   assign start_o = start_q;
   assign busy_o  = busy_q;

   a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_q |=> !start_q);

   a_r6_no_start_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !conv_en_i |=> !start_q);

   a_r7_drop_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !done_evt_o) |=> !start_q);

   a_r7_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_q |-> busy_q);

endmodule

// File: rtl/chan_sync.sv
module chan_sync #(
   parameter int CHW = 6
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           busy_i,
   input  logic           done_evt_i,
   input  logic           wr_i,
   input  logic [CHW-1:0] wdata_i,
   output logic [CHW-1:0] chan_o
);

   logic [CHW-1:0] chan_q;
   logic [CHW-1:0] pend_q;
   logic           pend_vld_q;
   logic           open;

   assign open = ~busy_i | done_evt_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chan_q     <= '0;
         pend_q     <= '0;
         pend_vld_q <= 1'b0;
      end else if (wr_i) begin
         if (open) begin
            chan_q     <= wdata_i;
            pend_vld_q <= 1'b0;
         end else begin
            pend_q     <= wdata_i;
            pend_vld_q <= 1'b1;
         end
      end else if (pend_vld_q && open) begin
         chan_q     <= pend_q;
         pend_vld_q <= 1'b0;
      end
   end

   assign chan_o = chan_q;

   a_r8_hold_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && !done_evt_i) |=> $stable(chan_q));

   a_r8_idle_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !busy_i) |=> (chan_q == $past(wdata_i)));

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
   import adc_trig_pkg::*;
#(
   parameter int         NSRC      = 8,
   parameter int         CHW       = 6,
   parameter mux_style_e MUX_STYLE = MUX_ANDOR,
   localparam int        SELW      = $clog2(NSRC)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-2:0] periph_flag_i,
   input  logic            done_flag_i,
   input  logic [SELW-1:0] src_sel_i,
   input  logic            auto_en_i,
   input  logic            conv_en_i,
   input  logic            chan_wr_i,
   input  logic [CHW-1:0]  chan_wdata_i,
   output logic            start_o,
   output logic [CHW-1:0]  chan_sel_o
);

   localparam logic [SELW-1:0] FREE_CODE = '0;

   initial begin : p_elab_chk
      if (!is_pow2(NSRC)) $fatal(1, "NSRC must be a power of two >= 2");
      if (CHW < 1)        $fatal(1, "CHW must be at least 1");
   end

   logic lvl;
   logic edge_hit;
   logic busy;
   logic done_evt;

   trig_src_mux #(
      .NSRC  (NSRC),
      .STYLE (MUX_STYLE)
   ) u_mux (
      .periph_i (periph_flag_i),
      .done_i   (done_flag_i),
      .sel_i    (src_sel_i),
      .lvl_o    (lvl)
   );

   trig_edge_det #(
      .SELW      (SELW),
      .FREE_CODE (FREE_CODE)
   ) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl),
      .sel_i  (src_sel_i),
      .edge_o (edge_hit)
   );

   conv_tracker u_trk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .edge_i      (edge_hit),
      .auto_en_i   (auto_en_i),
      .conv_en_i   (conv_en_i),
      .done_flag_i (done_flag_i),
      .start_o     (start_o),
      .busy_o      (busy),
      .done_evt_o  (done_evt)
   );

   chan_sync #(
      .CHW (CHW)
   ) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .busy_i     (busy),
      .done_evt_i (done_evt),
      .wr_i       (chan_wr_i),
      .wdata_i    (chan_wdata_i),
      .chan_o     (chan_sel_o)
   );

   a_r5_auto_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !auto_en_i |=> !start_o);

   a_r4_enter_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_sel_i == FREE_CODE && $past(src_sel_i) != FREE_CODE) |=> !start_o);

endmodule

// File: tb/test_adc_trig_sel.sv
module test_adc_trig_sel;

   localparam int NSRC = 8;
   localparam int CHW  = 6;
   localparam int SELW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-2:0] periph = '0;
   logic            done_f = 1'b0;
   logic [SELW-1:0] sel = '0;
   logic            auto_en = 1'b0;
   logic            conv_en = 1'b0;
   logic            wr = 1'b0;
   logic [CHW-1:0]  wdata = '0;
   logic            start;
   logic [CHW-1:0]  chan;

   int checks = 0;
   int fails  = 0;
   bit done_run = 1'b0;

   always #4 clk = ~clk;

   adc_trig_sel #(.NSRC(NSRC), .CHW(CHW)) i_adc_trig_sel (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .periph_flag_i (periph),
      .done_flag_i   (done_f),
      .src_sel_i     (sel),
      .auto_en_i     (auto_en),
      .conv_en_i     (conv_en),
      .chan_wr_i     (wr),
      .chan_wdata_i  (wdata),
      .start_o       (start),
      .chan_sel_o    (chan)
   );

   // Reference state derived from the requirements
   bit             m_prev, m_cprev, m_busy, m_start, m_pv;
   bit [SELW-1:0]  m_selq;
   bit [CHW-1:0]   m_chan, m_pend;

   function automatic bit f_lvl(input bit [SELW-1:0] s, input bit [NSRC-2:0] p,
                                input bit d);
      return (s == 0) ? d : p[s-1];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_prev = 0; m_cprev = 0; m_busy = 0; m_start = 0; m_pv = 0;
      m_selq = 0; m_chan = 0; m_pend = 0;
   endtask

   // One clock: advance the model from the present inputs, then compare.
   task automatic tick(input string tag);
      bit lv, edg, dev, acc, open;
      lv   = f_lvl(sel, periph, done_f);
      edg  = lv && !m_prev && !(sel == 0 && m_selq != 0);
      dev  = done_f && !m_cprev;
      acc  = edg && auto_en && conv_en && (!m_busy || dev);
      open = !m_busy || dev;
      if (wr) begin
         if (open) begin m_chan = wdata; m_pv = 0; end
         else begin m_pend = wdata; m_pv = 1; end
      end else if (m_pv && open) begin
         m_chan = m_pend; m_pv = 0;
      end
      if (!conv_en) m_busy = 0;
      else if (acc) m_busy = 1;
      else if (dev) m_busy = 0;
      m_start = acc;
      m_prev  = lv;
      m_selq  = sel;
      m_cprev = done_f;
      @(posedge clk);
      @(negedge clk);
      chk({tag, " start"}, 32'(start), 32'(m_start));
      chk({tag, " chan"},  32'(chan),  32'(m_chan));
   endtask

   task automatic finish_conv();
      done_f = 1'b1; tick("R7 completion");
      done_f = 1'b0; tick("R7 completion");
   endtask

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      if (!done_run) begin
         fails++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : p_main
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      model_reset();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 start", 32'(start), 32'd0);
      chk("R1 chan",  32'(chan),  32'd0);
      rst_n = 1'b1;
      conv_en = 1'b1; auto_en = 1'b1; sel = 3'd1;
      tick("R1 idle");

      // R2: code 3 picks periph bit 2
      sel = 3'd3; tick("R2 setup");
      periph[2] = 1'b1; tick("R2 edge");
      chk("R2 explicit start", 32'(start), 32'd1);
      tick("R9 level held");
      chk("R9 explicit no repeat", 32'(start), 32'd0);
      finish_conv();

      // R3: select change low -> high
      periph = '0; sel = 3'd1; tick("R3 setup");
      periph[5] = 1'b1; tick("R3 setup");
      sel = 3'd6; tick("R3 switch");
      chk("R3 explicit start", 32'(start), 32'd1);
      finish_conv();

      // R4: entering free-run with flag high
      periph = '0; sel = 3'd1; tick("R4 setup");
      done_f = 1'b1; tick("R4 setup");
      sel = 3'd0; tick("R4 switch");
      chk("R4 explicit no start", 32'(start), 32'd0);
      tick("R4 hold");
      chk("R4 explicit no start later", 32'(start), 32'd0);
      done_f = 1'b0; tick("R2 free run low");
      done_f = 1'b1; tick("R2 free run edge");
      chk("R2 explicit free run start", 32'(start), 32'd1);
      done_f = 1'b0; tick("R7 free run");
      done_f = 1'b1; tick("R7 completion cycle edge");
      chk("R7 explicit accept at completion", 32'(start), 32'd1);
      done_f = 1'b0; sel = 3'd1; tick("R7 leave free run");
      finish_conv();

      // R7: edge during a conversion is dropped, not queued
      sel = 3'd2; tick("R7 setup");
      periph[1] = 1'b1; tick("R7 first");
      chk("R7 explicit first start", 32'(start), 32'd1);
      periph[1] = 1'b0; tick("R7 low");
      periph[1] = 1'b1; tick("R7 busy edge");
      chk("R7 explicit dropped", 32'(start), 32'd0);
      done_f = 1'b1; tick("R7 no queue");
      chk("R7 explicit not queued", 32'(start), 32'd0);
      done_f = 1'b0; tick("R7 no queue");
      chk("R7 explicit still none", 32'(start), 32'd0);
      periph = '0;

      // R5: auto enable off, then on with source already high
      auto_en = 1'b0; sel = 3'd4; tick("R5 setup");
      periph[3] = 1'b1; tick("R5 edge while off");
      chk("R5 explicit no start", 32'(start), 32'd0);
      auto_en = 1'b1; tick("R5 enable on high");
      chk("R5 explicit no stale edge", 32'(start), 32'd0);

      // R6: converter disabled
      conv_en = 1'b0; periph[3] = 1'b0; tick("R6 setup");
      periph[3] = 1'b1; tick("R6 edge while off");
      chk("R6 explicit no start", 32'(start), 32'd0);
      conv_en = 1'b1; periph = '0; tick("R6 restore");

      // R8: idle write, then writes during a conversion
      wr = 1'b1; wdata = 6'h15; tick("R8 idle write");
      chk("R8 explicit idle apply", 32'(chan), 32'h15);
      wr = 1'b0; sel = 3'd5; tick("R8 setup");
      periph[4] = 1'b1; tick("R8 start");
      wr = 1'b1; wdata = 6'h2A; tick("R8 held write");
      chk("R8 explicit held", 32'(chan), 32'h15);
      wdata = 6'h0C; tick("R8 second held write");
      wr = 1'b0; tick("R8 wait");
      chk("R8 explicit still held", 32'(chan), 32'h15);
      done_f = 1'b1; tick("R8 completion");
      chk("R8 explicit applied last", 32'(chan), 32'h0C);
      done_f = 1'b0; periph = '0; tick("R8 after");

      // Constrained random mix against the reference
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(15) == 0) sel = SELW'($urandom_range(NSRC-1));
         for (int b = 0; b < NSRC-1; b++)
            if ($urandom_range(7) == 0) periph[b] = ~periph[b];
         if ($urandom_range(5) == 0) done_f = ~done_f;
         if ($urandom_range(63) == 0) auto_en = ~auto_en;
         if ($urandom_range(63) == 0) conv_en = ~conv_en;
         wr    = ($urandom_range(9) == 0);
         wdata = CHW'($urandom);
         tick("R2/R7/R8 random");
      end

      done_run = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule